// File: doc/BRIEF.md
# USB Packet Field Parser

This block sits behind a USB line receiver that has already undone NRZI coding and removed stuffed bits. It takes one received bit per `bit_valid_i` cycle, in arrival order, plus a strobe that opens a packet and a strobe that closes it. From this stream it checks the leading sync byte and classifies the packet by its PID. It then splits the rest of the packet into fields while the bits are still arriving.

Token packets (OUT, IN, SETUP) yield a device address and an endpoint number. Start-of-frame packets yield a frame number. Data packets yield a stream of payload bytes. The trailing CRC field is cut off and never shown as payload. It is 5 bits after token and SOF fields and 16 bits after data. The CRC value itself is not checked.

A data packet's length is only known when the packet closes. For that reason, payload bits pass through a 16-bit delay line, and a byte leaves only once 16 newer bits have arrived behind it.

Top module: `usbpf_parser`

## Requirements
- R1: Bits are taken only from the `pkt_start_i` cycle through the `pkt_end_i` cycle. A bit outside that span, or a `pkt_end_i` outside a packet, produces no output pulse.
- R2: One cycle after the 8th bit is taken, `sync_err_o` pulses if the first seven bits were not all 0 or the eighth was not 1. Read with the first bit as LSB, the sync byte must equal 0x80.
- R3: One cycle after the 16th bit is taken, `pid_valid_o` pulses once. `pid_o` then holds PID bits 0-3, taking the first PID bit as bit 0.
- R4: `pid_kind_o` is updated with that pulse and holds until the next packet start. The PID bytes are read first-bit-as-LSB.
  - 1 (token): 0xE1, 0x69, 0x2D.
  - 2 (SOF): 0xA5.
  - 3 (data): 0xC3, 0x4B.
  - 4 (handshake): 0xD2, 0x5A, 0x1E, 0x96.
  - 5: any other PID whose check nibble is correct.
  - 0: no PID decoded yet, or a PID error.
- R5: `pid_err_o` pulses with `pid_valid_o` when PID bits 4-7 are not the bitwise complement of bits 0-3. `pid_kind_o` is then 0.
- R6: A token packet of exactly 32 bits gives a `tok_valid_o` pulse one cycle after `pkt_end_i`. `tok_addr_o` is payload bits 0-6 and `tok_ep_o` is payload bits 7-10, both LSB first.
- R7: An SOF packet of exactly 32 bits gives a `sof_valid_o` pulse one cycle after `pkt_end_i`. `sof_frame_o` is payload bits 0-10, LSB first.
- R8: A token or SOF packet of any other length gives a `len_err_o` pulse one cycle after `pkt_end_i`, and no `tok_valid_o` or `sof_valid_o`.
- R9: In a data packet, payload bits are grouped into bytes LSB first.
  - A byte is presented on `byte_o` with a `byte_valid_o` pulse one cycle after the bit taken 16 payload bits after the byte's last bit.
  - A payload of P bits yields exactly floor((P-16)/8) bytes, so the last 16 bits are never output.
- R10: Handshake, other-kind and PID-error packets produce no token, SOF, byte or length-error pulse, whatever bits follow the PID.
- R11: A bit may arrive in the same cycle as `pkt_start_i`, where it is the first sync bit. A bit may also arrive in the same cycle as `pkt_end_i`, where it is the last bit of the packet. Either way, the results equal those of separate strobes.
- R12: During and straight after reset all pulse outputs are 0 and `pid_kind_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid_i | input | 1 | A received bit is present this cycle |
| bit_i | input | 1 | Received bit value |
| pkt_start_i | input | 1 | Packet opens this cycle |
| pkt_end_i | input | 1 | Packet closes this cycle |
| sync_err_o | output | 1 | Sync byte mismatch pulse |
| pid_valid_o | output | 1 | PID decoded pulse |
| pid_o | output | 4 | PID type nibble |
| pid_kind_o | output | 3 | Packet class code |
| pid_err_o | output | 1 | PID check nibble mismatch pulse |
| tok_valid_o | output | 1 | Token fields valid pulse |
| tok_addr_o | output | 7 | Device address |
| tok_ep_o | output | 4 | Endpoint number |
| sof_valid_o | output | 1 | Frame number valid pulse |
| sof_frame_o | output | 11 | Frame number |
| len_err_o | output | 1 | Token or SOF length error pulse |
| byte_valid_o | output | 1 | Payload byte valid pulse |
| byte_o | output | 8 | Payload byte |

## Verification
Two functions can fall in the same cycle: the release of the final payload byte out of the delay line, and the close of the packet. The same holds for token and PID field capture at the close when the last bit rides on the `pkt_end_i` strobe. The bench sends every data, token, SOF and PID sweep packet both with the last bit merged into the end strobe and with a separate end strobe, and likewise with and without a merged start. Byte counts, byte values, field values and error pulses must be identical in both forms and match the arithmetic expectation.

// File: rtl/usbpf_pkg.sv
package usbpf_pkg;
    localparam int SYNC_BITS = 8;
    localparam int PID_BITS  = 8;
    localparam int HDR_BITS  = SYNC_BITS + PID_BITS;
    localparam int ADDR_W    = 7;
    localparam int EP_W      = 4;
    localparam int FRAME_W   = 11;
    localparam int TCRC_W    = 5;
    localparam int DCRC_W    = 16;
    localparam int TOK_PAY   = ADDR_W + EP_W + TCRC_W;
    localparam int TOK_BITS  = HDR_BITS + TOK_PAY;
    localparam logic [SYNC_BITS-1:0] SYNC_VAL = 8'h80;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_TOKEN = 3'd1,
        K_SOF   = 3'd2,
        K_DATA  = 3'd3,
        K_HAND  = 3'd4,
        K_OTHER = 3'd5
    } kind_t;

    function automatic kind_t pid_class(input logic [PID_BITS-1:0] v);
        kind_t k;
        if (v[7:4] != ~v[3:0]) begin
            k = K_NONE;
        end else begin
            case (v[3:0])
                4'h1, 4'h9, 4'hD:       k = K_TOKEN;
                4'h5:                   k = K_SOF;
                4'h3, 4'hB:             k = K_DATA;
                4'h2, 4'hA, 4'hE, 4'h6: k = K_HAND;
                default:                k = K_OTHER;
            endcase
        end
        return k;
    endfunction
endpackage

// File: rtl/usbpf_hdr.sv
module usbpf_hdr
    import usbpf_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid_i,
    input  logic             bit_i,
    input  logic             start_i,
    input  logic             end_i,
    output logic             take_o,
    output logic             end_o,
    output logic [CNT_W-1:0] pos_o,
    output kind_t            kind_q_o,
    output kind_t            kind_d_o,
    output logic             pid_valid_o,
    output logic [3:0]       pid_o,
    output logic             pid_err_o,
    output logic             sync_err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] POS_SYNC = CNT_W'(SYNC_BITS - 1);
    localparam logic [CNT_W-1:0] POS_PID  = CNT_W'(HDR_BITS - 1);

    typedef struct packed {
        logic                active;
        logic [CNT_W-1:0]    cnt;
        logic [PID_BITS-1:0] sr;
        kind_t               kind;
        logic                pid_valid;
        logic [3:0]          pid;
        logic                pid_err;
        logic                sync_err;
    } hdr_st_t;

    hdr_st_t q, d;
    logic [CNT_W-1:0]    base;
    logic [PID_BITS-1:0] sr_nx;
    logic                take;

    always_comb begin
        d           = q;
        d.pid_valid = 1'b0;
        d.pid_err   = 1'b0;
        d.sync_err  = 1'b0;
        base        = start_i ? '0 : q.cnt;
        take        = bit_valid_i && (q.active || start_i);
        sr_nx       = {bit_i, q.sr[PID_BITS-1:1]};
        if (start_i) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.kind   = K_NONE;
        end
        if (take) begin
            d.sr = sr_nx;
            if (base != CNT_MAX) begin
                d.cnt = base + CNT_W'(1);
            end
            if (base == POS_SYNC) begin
                d.sync_err = (sr_nx != SYNC_VAL);
            end
            if (base == POS_PID) begin
                d.pid_valid = 1'b1;
                d.pid       = sr_nx[3:0];
                d.pid_err   = (sr_nx[7:4] != ~sr_nx[3:0]);
                d.kind      = pid_class(sr_nx);
            end
        end
        if (end_i && q.active) begin
            d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign take_o      = take;
    assign end_o       = end_i && q.active;
    assign pos_o       = base;
    assign kind_q_o    = q.kind;
    assign kind_d_o    = d.kind;
    assign pid_valid_o = q.pid_valid;
    assign pid_o       = q.pid;
    assign pid_err_o   = q.pid_err;
    assign sync_err_o  = q.sync_err;

    p_pid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pid_valid_o |=> !pid_valid_o);
    p_err_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pid_err_o |-> (pid_valid_o && kind_q_o == K_NONE));
    p_sync_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err_o |-> !pid_valid_o);
endmodule

// File: rtl/usbpf_tok.sv
module usbpf_tok
    import usbpf_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic               bit_i,
    input  logic               end_i,
    input  logic [CNT_W-1:0]   pos_i,
    input  kind_t              kind_i,
    output logic               tok_valid_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [EP_W-1:0]    ep_o,
    output logic               sof_valid_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               len_err_o
);
    localparam logic [CNT_W-1:0] POS_LO  = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] POS_HI  = CNT_W'(TOK_BITS);
    localparam logic [CNT_W:0]   LEN_OK  = (CNT_W+1)'(TOK_BITS);

    typedef struct packed {
        logic [TOK_PAY-1:0] fld;
        logic [ADDR_W-1:0]  addr;
        logic [EP_W-1:0]    ep;
        logic [FRAME_W-1:0] frame;
        logic               tok_valid;
        logic               sof_valid;
        logic               len_err;
    } tok_st_t;

    tok_st_t q, d;
    logic [CNT_W:0] total;

    always_comb begin
        d           = q;
        d.tok_valid = 1'b0;
        d.sof_valid = 1'b0;
        d.len_err   = 1'b0;
        total       = {1'b0, pos_i} + {{CNT_W{1'b0}}, take_i};
        if (take_i && pos_i >= POS_LO && pos_i < POS_HI) begin
            d.fld = {bit_i, q.fld[TOK_PAY-1:1]};
        end
        if (end_i && (kind_i == K_TOKEN || kind_i == K_SOF)) begin
            if (total != LEN_OK) begin
                d.len_err = 1'b1;
            end else if (kind_i == K_TOKEN) begin
                d.tok_valid = 1'b1;
                d.addr      = d.fld[ADDR_W-1:0];
                d.ep        = d.fld[ADDR_W+EP_W-1:ADDR_W];
            end else begin
                d.sof_valid = 1'b1;
                d.frame     = d.fld[FRAME_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tok_valid_o = q.tok_valid;
    assign addr_o      = q.addr;
    assign ep_o        = q.ep;
    assign sof_valid_o = q.sof_valid;
    assign frame_o     = q.frame;
    assign len_err_o   = q.len_err;

    p_one_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tok_valid_o, sof_valid_o, len_err_o}));
    p_result_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid_o || sof_valid_o || len_err_o) |=> !(tok_valid_o || sof_valid_o || len_err_o));
endmodule

// File: rtl/usbpf_dat.sv
module usbpf_dat
    import usbpf_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             bit_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] pos_i,
    input  kind_t            kind_i,
    output logic             byte_valid_o,
    output logic [7:0]       byte_o
);
    localparam logic [CNT_W-1:0] POS_PAY  = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] POS_FULL = CNT_W'(HDR_BITS + DCRC_W);

    typedef struct packed {
        logic [DCRC_W-1:0] dl;
        logic [7:0]        sh;
        logic [2:0]        idx;
        logic              bv;
        logic [7:0]        bd;
    } dat_st_t;

    dat_st_t q, d;
    logic [7:0] sh_nx;
    logic       pay;

    always_comb begin
        d     = q;
        d.bv  = 1'b0;
        sh_nx = {q.dl[0], q.sh[7:1]};
        pay   = take_i && (pos_i >= POS_PAY) && (kind_i == K_DATA);
        if (start_i) begin
            d.idx = '0;
        end
        if (pay) begin
            d.dl = {bit_i, q.dl[DCRC_W-1:1]};
            if (pos_i >= POS_FULL) begin
                d.sh  = sh_nx;
                d.idx = q.idx + 3'd1;
                if (q.idx == 3'd7) begin
                    d.bv = 1'b1;
                    d.bd = sh_nx;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign byte_valid_o = q.bv;
    assign byte_o       = q.bd;

    p_byte_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o);
    p_byte_data_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> $past(kind_i) == K_DATA);
endmodule

// File: rtl/usbpf_parser.sv
module usbpf_parser
    import usbpf_pkg::*;
#(
    parameter int MAX_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_valid_i,
    input  logic        bit_i,
    input  logic        pkt_start_i,
    input  logic        pkt_end_i,
    output logic        sync_err_o,
    output logic        pid_valid_o,
    output logic [3:0]  pid_o,
    output logic [2:0]  pid_kind_o,
    output logic        pid_err_o,
    output logic        tok_valid_o,
    output logic [6:0]  tok_addr_o,
    output logic [3:0]  tok_ep_o,
    output logic        sof_valid_o,
    output logic [10:0] sof_frame_o,
    output logic        len_err_o,
    output logic        byte_valid_o,
    output logic [7:0]  byte_o
);
    localparam int MAX_BITS = HDR_BITS + 8 * MAX_BYTES + DCRC_W;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    logic             take;
    logic             pend;
    logic [CNT_W-1:0] pos;
    kind_t            kind_q;
    kind_t            kind_d;

    usbpf_hdr #(.CNT_W(CNT_W)) u_hdr (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_valid_i (bit_valid_i),
        .bit_i       (bit_i),
        .start_i     (pkt_start_i),
        .end_i       (pkt_end_i),
        .take_o      (take),
        .end_o       (pend),
        .pos_o       (pos),
        .kind_q_o    (kind_q),
        .kind_d_o    (kind_d),
        .pid_valid_o (pid_valid_o),
        .pid_o       (pid_o),
        .pid_err_o   (pid_err_o),
        .sync_err_o  (sync_err_o)
    );

    usbpf_tok #(.CNT_W(CNT_W)) u_tok (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .bit_i       (bit_i),
        .end_i       (pend),
        .pos_i       (pos),
        .kind_i      (kind_d),
        .tok_valid_o (tok_valid_o),
        .addr_o      (tok_addr_o),
        .ep_o        (tok_ep_o),
        .sof_valid_o (sof_valid_o),
        .frame_o     (sof_frame_o),
        .len_err_o   (len_err_o)
    );

    usbpf_dat #(.CNT_W(CNT_W)) u_dat (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_i       (take),
        .bit_i        (bit_i),
        .start_i      (pkt_start_i),
        .pos_i        (pos),
        .kind_i       (kind_d),
        .byte_valid_o (byte_valid_o),
        .byte_o       (byte_o)
    );

    assign pid_kind_o = kind_q;

    p_tok_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid_o |-> pid_kind_o == K_TOKEN);
    p_sof_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sof_valid_o |-> pid_kind_o == K_SOF);
endmodule

// File: tb/usbpf_parser_bench.sv
module usbpf_parser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid_i = 1'b0;
    logic        bit_i = 1'b0;
    logic        pkt_start_i = 1'b0;
    logic        pkt_end_i = 1'b0;
    logic        sync_err_o, pid_valid_o, pid_err_o, tok_valid_o, sof_valid_o, len_err_o, byte_valid_o;
    logic [3:0]  pid_o;
    logic [2:0]  pid_kind_o;
    logic [6:0]  tok_addr_o;
    logic [3:0]  tok_ep_o;
    logic [10:0] sof_frame_o;
    logic [7:0]  byte_o;

    usbpf_parser u_usbpf_parser (
        .clk(clk), .rst_n(rst_n), .bit_valid_i(bit_valid_i), .bit_i(bit_i),
        .pkt_start_i(pkt_start_i), .pkt_end_i(pkt_end_i),
        .sync_err_o(sync_err_o), .pid_valid_o(pid_valid_o), .pid_o(pid_o),
        .pid_kind_o(pid_kind_o), .pid_err_o(pid_err_o), .tok_valid_o(tok_valid_o),
        .tok_addr_o(tok_addr_o), .tok_ep_o(tok_ep_o), .sof_valid_o(sof_valid_o),
        .sof_frame_o(sof_frame_o), .len_err_o(len_err_o),
        .byte_valid_o(byte_valid_o), .byte_o(byte_o)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    int n_pidv, n_sync, n_pide, n_tok, n_sof, n_len, n_byte;
    logic [3:0]  m_pid;
    logic [2:0]  m_kind;
    logic [6:0]  m_addr;
    logic [3:0]  m_ep;
    logic [10:0] m_frame;
    logic [7:0]  m_bytes [0:63];

    logic pb [0:2047];
    int   plen;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (pid_valid_o) begin n_pidv++; m_pid = pid_o; m_kind = pid_kind_o; end
            if (pid_err_o) n_pide++;
            if (sync_err_o) n_sync++;
            if (tok_valid_o) begin n_tok++; m_addr = tok_addr_o; m_ep = tok_ep_o; end
            if (sof_valid_o) begin n_sof++; m_frame = sof_frame_o; end
            if (len_err_o) n_len++;
            if (byte_valid_o) begin
                if (n_byte < 64) m_bytes[n_byte] = byte_o;
                n_byte++;
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_kind(input logic [7:0] v);
        if (v[7:4] != ~v[3:0]) return 0;
        case (v[3:0])
            4'h1, 4'h9, 4'hD:       return 1;
            4'h5:                   return 2;
            4'h3, 4'hB:             return 3;
            4'h2, 4'hA, 4'hE, 4'h6: return 4;
            default:                return 5;
        endcase
    endfunction

    task automatic clr_mon();
        n_pidv = 0; n_sync = 0; n_pide = 0; n_tok = 0; n_sof = 0; n_len = 0; n_byte = 0;
    endtask

    task automatic put_bits(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            pb[plen] = v[i];
            plen++;
        end
    endtask

    task automatic put_hdr(input logic [7:0] pid);
        plen = 0;
        put_bits(32'h80, 8);
        put_bits({24'h0, pid}, 8);
    endtask

    task automatic send(input bit ms, input bit me);
        clr_mon();
        @(negedge clk);
        if (!ms) begin
            pkt_start_i = 1'b1;
            @(negedge clk);
            pkt_start_i = 1'b0;
        end
        for (int i = 0; i < plen; i++) begin
            pkt_start_i = ms && (i == 0);
            bit_valid_i = 1'b1;
            bit_i       = pb[i];
            pkt_end_i   = me && (i == plen - 1);
            @(negedge clk);
        end
        bit_valid_i = 1'b0;
        pkt_start_i = 1'b0;
        pkt_end_i   = 1'b0;
        if (!me) begin
            pkt_end_i = 1'b1;
            @(negedge clk);
            pkt_end_i = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic loose_bits(input int n);
        clr_mon();
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            bit_valid_i = 1'b1;
            bit_i       = (i % 3 == 0);
            @(negedge clk);
        end
        bit_valid_i = 1'b0;
        pkt_end_i   = 1'b1;
        @(negedge clk);
        pkt_end_i   = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset pulses", {pid_valid_o, sync_err_o, tok_valid_o, sof_valid_o, len_err_o, byte_valid_o, pid_err_o}, 0);
        chk("R12 reset kind", pid_kind_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 after reset pulses", {pid_valid_o, sync_err_o, tok_valid_o, sof_valid_o, len_err_o, byte_valid_o, pid_err_o}, 0);
        chk("R12 after reset kind", pid_kind_o, 0);

        // R1: bits with no open packet
        loose_bits(40);
        chk("R1 idle bits pid", n_pidv + n_sync + n_pide, 0);
        chk("R1 idle bits fields", n_tok + n_sof + n_len + n_byte, 0);

        // R3 R4 R5 R11: full PID sweep, header-only packets
        for (int v = 0; v < 256; v++) begin
            int k;
            k = exp_kind(8'(v));
            put_hdr(8'(v));
            send(v[0], v[1]);
            chk("R3 pid pulse", n_pidv, 1);
            chk("R3 pid nibble", m_pid, v % 16);
            chk("R4 kind", m_kind, k);
            chk("R5 pid err", n_pide, (k == 0) ? 1 : 0);
            chk("R2 good sync", n_sync, 0);
            chk("R8 short token len err", n_len, (k == 1 || k == 2) ? 1 : 0);
            chk("R10 no fields", n_tok + n_sof + n_byte, 0);
        end

        // R1: stray bits after a closed packet
        loose_bits(24);
        chk("R1 bits after end", n_pidv + n_sync + n_tok + n_sof + n_len + n_byte, 0);

        // R2: each single sync bit flipped
        for (int b = 0; b < 8; b++) begin
            plen = 0;
            put_bits(32'h80 ^ (32'h1 << b), 8);
            put_bits(32'hD2, 8);
            send(b[0], 1'b0);
            chk("R2 sync err", n_sync, 1);
            chk("R2 pid still decoded", n_pidv, 1);
        end

        // R6 R11: token sweep over all addresses
        for (int a = 0; a < 128; a++) begin
            logic [7:0] tp;
            int ep;
            tp = (a % 3 == 0) ? 8'hE1 : ((a % 3 == 1) ? 8'h69 : 8'h2D);
            ep = (a * 5) % 16;
            put_hdr(tp);
            put_bits(32'(a), 7);
            put_bits(32'(ep), 4);
            put_bits(32'(a % 32), 5);
            send(a[0], a[1]);
            chk("R6 tok pulse", n_tok, 1);
            chk("R6 addr", m_addr, a);
            chk("R6 ep", m_ep, ep);
            chk("R8 no len err", n_len, 0);
            chk("R6 no bytes", n_byte + n_sof, 0);
        end

        // R7: SOF frame sweep
        for (int f = 0; f < 2048 + 73; f += 73) begin
            int fr;
            fr = (f > 2047) ? 2047 : f;
            put_hdr(8'hA5);
            put_bits(32'(fr), 11);
            put_bits(32'(fr % 31), 5);
            send(fr[2], fr[0]);
            chk("R7 sof pulse", n_sof, 1);
            chk("R7 frame", m_frame, fr);
            chk("R7 no tok", n_tok + n_len, 0);
        end

        // R8: wrong payload lengths for token and SOF
        for (int j = 0; j < 6; j++) begin
            int pl;
            pl = (j % 3 == 0) ? 15 : ((j % 3 == 1) ? 17 : 24);
            put_hdr((j < 3) ? 8'hE1 : 8'hA5);
            put_bits(32'h5A5A5A, pl);
            send(1'b0, j[0]);
            chk("R8 len err", n_len, 1);
            chk("R8 no valid", n_tok + n_sof, 0);
        end

        // R9 R11: data packets of 0..12 bytes, both strobe forms
        for (int nb = 0; nb <= 12; nb++) begin
            for (int m = 0; m < 2; m++) begin
                put_hdr((nb % 2 == 1) ? 8'h4B : 8'hC3);
                for (int k = 0; k < nb; k++) put_bits(32'((nb * 37 + k * 11 + 5) % 256), 8);
                put_bits(32'(16'hA55A ^ nb), 16);
                send(m[0], m[0]);
                chk("R9 byte count", n_byte, nb);
                for (int k = 0; k < nb; k++)
                    chk("R9 byte value", m_bytes[k], (nb * 37 + k * 11 + 5) % 256);
                chk("R9 no token", n_tok + n_sof + n_len, 0);
            end
        end

        // R9: payload not a whole number of bytes
        put_hdr(8'hC3);
        put_bits(32'h3C, 8);
        put_bits(32'hC5, 8);
        put_bits(32'h5, 3);
        put_bits(32'hFFFF, 16);
        send(1'b0, 1'b1);
        chk("R9 partial count", n_byte, 2);
        chk("R9 partial b0", m_bytes[0], 8'h3C);
        chk("R9 partial b1", m_bytes[1], 8'hC5);

        // R10: handshake and error PIDs with trailing bits
        put_hdr(8'hD2);
        put_bits(32'hFFFF_FFFF, 32);
        send(1'b0, 1'b0);
        chk("R10 handshake trailing", n_tok + n_sof + n_len + n_byte, 0);
        put_hdr(8'hC4);
        put_bits(32'h1234_5678, 32);
        send(1'b1, 1'b1);
        chk("R10 bad pid trailing", n_tok + n_sof + n_len + n_byte, 0);
        chk("R5 bad pid flagged", n_pide, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule